// File: doc/BRIEF.md
# Handshake-Completed Memory-Mapped Port Target

This block sits on a 32-bit processor bus as a small I/O target with two 8-bit registers. One register samples an external input port. The other drives an external output port and can be read back. The two registers occupy two consecutive word addresses starting at a base word address that is set by a parameter. The processor sends only bits 31..2 of the address. Byte selection comes from four per-lane enable lines.

Each access completes with a level-sensitive four-phase exchange. The processor first settles address, lane enables, direction and write data, and then raises its master enable. The target acts once and raises its acknowledge. It holds the acknowledge high until master enable drops, and then releases it. While master enable is low the target ignores every other bus input. This means values that are still changing on the bus can never be acted on.

The stored register sits on byte lane 0. A write changes it only when lane 0 is enabled. A read returns it on lane 0 and returns zero on every other bit.

Top module: `hsk_bus_target`

## Requirements
- R1: After reset, `bus_ack` is 0, `bus_rdata` is 0 and `port_out` is 0.
- R2: While `bus_men` is 0, the target does not raise `bus_ack` and does not change `port_out`, whatever the other bus inputs do.
- R3: When `bus_men` is 1 at a clock edge, `bus_ack` is 0 and `bus_waddr` equals the base word address (input register) or the base plus one (output register), the target raises `bus_ack` at that edge.
- R4: `bus_ack` stays 1 for as long as `bus_men` stays 1. It returns to 0 at the first clock edge where `bus_men` is seen at 0.
- R5: A write (`bus_rd_nwr` = 0) to base+1 with `bus_be[0]` = 1 loads `bus_wdata[7:0]` into `port_out` at the edge where `bus_ack` rises.
- R6: A write to base+1 with `bus_be[0]` = 0 is acknowledged but leaves `port_out` unchanged.
- R7: A write to the base address (input register) is acknowledged but changes no stored state.
- R8: A read (`bus_rd_nwr` = 1) of the base address returns `{24'b0, port_in}` when `bus_be[0]` = 1. Here `port_in` is the value sampled one clock edge before the acknowledge rises. The read returns all zeros when `bus_be[0]` = 0.
- R9: A read of base+1 returns `{24'b0, port_out}` when `bus_be[0]` = 1, and all zeros otherwise.
- R10: An access whose word address matches neither register is never acknowledged, however long `bus_men` stays high.
- R11: Each access updates `port_out` at most once, at the rise of `bus_ack`. Changes to `bus_wdata` while the acknowledge is held have no effect.
- R12: `bus_rdata` is all zeros whenever `bus_ack` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_waddr | input | 30 | Word address, byte address bits 31..2 |
| bus_be | input | 4 | Per-lane byte enables, bit n marks lane n |
| bus_rd_nwr | input | 1 | 1 for read, 0 for write |
| bus_wdata | input | 32 | Write data from the processor |
| bus_men | input | 1 | Master enable; bus inputs are meaningful only while high |
| bus_rdata | output | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | Acknowledge of the current access |
| port_in | input | 8 | External input port |
| port_out | output | 8 | External output port |

## Verification
The assertions assume the processor follows the four-phase order. It raises master enable only once the acknowledge of the previous access has dropped, and it holds address, direction and lane enables steady while master enable is high. The stimulus tasks drive all of these on the falling clock edge, raise master enable one edge after the port value and bus fields are settled, and drop it only after observing the acknowledge. Some random write data is changed while the acknowledge is held, on purpose, to exercise R11. Between accesses the bench drives unrelated addresses and write data with master enable held low. Unmatched accesses hold master enable high for several cycles before dropping it without an acknowledge.

// File: rtl/hsk_bus_pkg.sv
package hsk_bus_pkg;
  typedef enum logic [0:0] {
    HS_IDLE = 1'b0,
    HS_HOLD = 1'b1
  } hs_state_t;

  localparam int unsigned BUS_W   = 32;
  localparam int unsigned LANES   = BUS_W / 8;
  localparam int unsigned WADDR_W = BUS_W - 2;
endpackage

// File: rtl/hsk_addr_decode.sv
module hsk_addr_decode #(
  parameter int unsigned            WADDR_W = 30,
  parameter logic [WADDR_W-1:0]     BASE    = '0
) (
  input  logic [WADDR_W-1:0] waddr,
  output logic               hit,
  output logic               sel_out
);
  localparam logic [WADDR_W-1:0] IN_WORD  = BASE;
  localparam logic [WADDR_W-1:0] OUT_WORD = BASE + 1'b1;

  logic match_in, match_out;

  always_comb begin
    match_in  = (waddr == IN_WORD);
    match_out = (waddr == OUT_WORD);
    hit       = match_in | match_out;
    sel_out   = match_out;
  end
endmodule

// File: rtl/hsk_handshake.sv
module hsk_handshake
  import hsk_bus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic men,
  input  logic hit,
  output logic accept,
  output logic release_now,
  output logic ack
);
  hs_state_t state_q, state_d;

  always_comb begin
    accept      = (state_q == HS_IDLE) && men && hit;
    release_now = (state_q == HS_HOLD) && !men;
    state_d     = state_q;
    if (accept)      state_d = HS_HOLD;
    if (release_now) state_d = HS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_IDLE;
    else        state_q <= state_d;
  end

  assign ack = (state_q == HS_HOLD);

  assert_ack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && men) |=> ack);
  assert_ack_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !men) |=> !ack);
  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!men && !ack) |=> !ack);
  assert_match_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (men && hit && !ack) |=> ack);
endmodule

// File: rtl/hsk_lane_regs.sv
module hsk_lane_regs #(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              release_now,
  input  logic              rd,
  input  logic              sel_out,
  input  logic              lane0_en,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [DATA_W-1:0] port_in,
  output logic [DATA_W-1:0] port_out,
  output logic [BUS_W-1:0]  rdata
);
  localparam int unsigned PAD_W = BUS_W - DATA_W;

  logic [DATA_W-1:0] in_q, out_q, pick;
  logic [BUS_W-1:0]  rdata_q;
  logic              load_out;

  always_comb begin
    pick     = sel_out ? out_q : in_q;
    load_out = accept && !rd && sel_out && lane0_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_q <= '0;
    else        in_q <= port_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_q <= '0;
    else if (load_out) out_q <= wdata[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (accept && rd) begin
      rdata_q <= lane0_en ? {{PAD_W{1'b0}}, pick} : '0;
    end else if (release_now) begin
      rdata_q <= '0;
    end
  end

  assign port_out = out_q;
  assign rdata    = rdata_q;

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[BUS_W-1:DATA_W] == '0);
endmodule

// File: rtl/hsk_bus_target.sv
module hsk_bus_target
  import hsk_bus_pkg::*;
#(
  parameter logic [WADDR_W-1:0] BASE_WADDR = 30'h0400_0020,
  parameter int unsigned        DATA_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WADDR_W-1:0] bus_waddr,
  input  logic [LANES-1:0]   bus_be,
  input  logic               bus_rd_nwr,
  input  logic [BUS_W-1:0]   bus_wdata,
  input  logic               bus_men,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               bus_ack,
  input  logic [DATA_W-1:0]  port_in,
  output logic [DATA_W-1:0]  port_out
);
  logic hit, sel_out, accept, release_now;

  hsk_addr_decode #(.WADDR_W(WADDR_W), .BASE(BASE_WADDR)) u_dec (
    .waddr   (bus_waddr),
    .hit     (hit),
    .sel_out (sel_out)
  );

  hsk_handshake u_hs (
    .clk         (clk),
    .rst_n       (rst_n),
    .men         (bus_men),
    .hit         (hit),
    .accept      (accept),
    .release_now (release_now),
    .ack         (bus_ack)
  );

  hsk_lane_regs #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .release_now (release_now),
    .rd          (bus_rd_nwr),
    .sel_out     (sel_out),
    .lane0_en    (bus_be[0]),
    .wdata       (bus_wdata),
    .port_in     (port_in),
    .port_out    (port_out),
    .rdata       (bus_rdata)
  );

  assert_miss_no_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !bus_ack) |=> !bus_ack);
  assert_single_update_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_out) |-> $rose(bus_ack));
  assert_rdata_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack |-> (bus_rdata == '0));
  assert_no_write_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd_nwr) |-> $stable(port_out));
endmodule

// File: tb/tb_hsk_bus_target.sv
`timescale 1ns/1ps
module tb_hsk_bus_target;
  localparam logic [29:0] BASE = 30'h0400_0020;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] bus_waddr = '0;
  logic [3:0]  bus_be = '0;
  logic        bus_rd_nwr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_men = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic [7:0]  port_in = '0;
  logic [7:0]  port_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model_out = '0;

  always #4 clk = ~clk;

  hsk_bus_target #(.BASE_WADDR(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .bus_waddr(bus_waddr), .bus_be(bus_be),
    .bus_rd_nwr(bus_rd_nwr), .bus_wdata(bus_wdata), .bus_men(bus_men),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .port_in(port_in),
    .port_out(port_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic sel_out, input logic be0,
                                           input logic [7:0] pin, input logic [7:0] pout);
    if (!be0) return 32'h0;
    return {24'h0, sel_out ? pout : pin};
  endfunction

  // Idle bus noise with men low (R2)
  task automatic idle_noise(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_waddr  = (($urandom % 2) == 0) ? BASE + 30'd1 : 30'($urandom);
      bus_be     = 4'($urandom);
      bus_rd_nwr = 1'($urandom);
      bus_wdata  = $urandom;
      bus_men    = 1'b0;
    end
    @(negedge clk);
    chk("R2 ack idle", {31'h0, bus_ack}, 32'h0);
    chk("R2 port_out idle", {24'h0, port_out}, {24'h0, model_out});
    chk("R12 rdata idle", bus_rdata, 32'h0);
  endtask

  task automatic access(input logic [29:0] wa, input logic [3:0] be, input logic rd,
                        input logic [31:0] wd, input logic [7:0] pin, input int hold);
    logic hitv, selv;
    logic [31:0] er;
    hitv = (wa == BASE) || (wa == BASE + 30'd1);
    selv = (wa == BASE + 30'd1);
    @(negedge clk);
    port_in = pin;
    bus_waddr = wa; bus_be = be; bus_rd_nwr = rd; bus_wdata = wd;
    @(negedge clk);
    er = exp_read(selv, be[0], pin, model_out);
    bus_men = 1'b1;
    @(negedge clk);
    if (!hitv) begin
      for (int i = 0; i < hold + 2; i++) begin
        chk("R10 miss never acked", {31'h0, bus_ack}, 32'h0);
        @(negedge clk);
      end
      bus_men = 1'b0;
      @(negedge clk);
      chk("R10 miss port_out", {24'h0, port_out}, {24'h0, model_out});
      return;
    end
    chk("R3 ack raised", {31'h0, bus_ack}, 32'h1);
    if (rd) begin
      chk(selv ? "R9 read output reg" : "R8 read input reg", bus_rdata, er);
    end else if (selv && be[0]) begin
      model_out = wd[7:0];
      chk("R5 write lane0", {24'h0, port_out}, {24'h0, model_out});
    end else if (selv) begin
      chk("R6 write lane0 off", {24'h0, port_out}, {24'h0, model_out});
    end else begin
      chk("R7 write input reg", {24'h0, port_out}, {24'h0, model_out});
    end
    for (int i = 0; i < hold; i++) begin
      if (!rd) bus_wdata = $urandom;
      @(negedge clk);
      chk("R4 ack held", {31'h0, bus_ack}, 32'h1);
      chk("R11 single update", {24'h0, port_out}, {24'h0, model_out});
    end
    bus_men = 1'b0;
    @(negedge clk);
    chk("R4 ack released", {31'h0, bus_ack}, 32'h0);
    chk("R12 rdata cleared", bus_rdata, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk("R1 ack reset", {31'h0, bus_ack}, 32'h0);
    chk("R1 rdata reset", bus_rdata, 32'h0);
    chk("R1 port_out reset", {24'h0, port_out}, 32'h0);
    rst_n = 1'b1;
    idle_noise(4);
    // directed corners
    access(BASE + 30'd1, 4'b0001, 1'b0, 32'hDEAD_BEA5, 8'h11, 0);  // R5
    access(BASE + 30'd1, 4'b1110, 1'b0, 32'h0000_0077, 8'h22, 2);  // R6
    access(BASE,         4'b1111, 1'b0, 32'h0000_0033, 8'h33, 1);  // R7
    access(BASE + 30'd1, 4'b1111, 1'b1, 32'h0,         8'h44, 3);  // R9
    access(BASE,         4'b0001, 1'b1, 32'h0,         8'hC6, 1);  // R8
    access(BASE,         4'b0010, 1'b1, 32'h0,         8'hC6, 1);  // R8 lane off
    access(BASE + 30'd2, 4'b1111, 1'b0, 32'h0000_00EE, 8'h55, 5);  // R10
    access(BASE - 30'd1, 4'b1111, 1'b1, 32'h0,         8'h66, 3);  // R10
    access(BASE + 30'd1, 4'b0001, 1'b0, 32'h0000_0081, 8'h00, 6);  // R11
    for (int n = 0; n < 200; n++) begin
      logic [29:0] wa;
      case ($urandom % 5)
        0, 1: wa = BASE + 30'd1;
        2, 3: wa = BASE;
        default: wa = 30'($urandom);
      endcase
      access(wa, 4'($urandom), 1'($urandom), $urandom, 8'($urandom), int'($urandom % 4));
      if ((n % 16) == 0) idle_noise(2);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule